// File: doc/BRIEF.md
# Dual-Width Integer Divide Unit

This block is the multicycle divider of a 16-bit processor datapath. After a one-cycle start pulse it divides either a 16-bit dividend by an 8-bit divisor (byte mode) or a 32-bit dividend by a 16-bit divisor (word mode). The operands are read as unsigned numbers or as two's-complement numbers, as the signed input selects. Internally the unit works on magnitudes with a restoring shift-subtract loop that produces one quotient bit per clock. It then restores the signs and writes the results to the accumulator and the second data register.

The operation can fail in two ways: the divisor is zero, or the quotient does not fit its destination. In either case the unit writes nothing and raises a one-cycle divide-error pulse in place of the done pulse. The surrounding core turns that pulse into a type-0 trap. Unsigned overflow is found before the loop starts: the upper half of the dividend magnitude is greater than or equal to the divisor. Signed overflow is found after the loop, against the signed range of the destination.

Top module: `intDivUnit`

## Requirements
- R1: In byte mode the dividend is `dividendLo` (16 bits) and the divisor is `divisor[7:0]`. On success `accOut[7:0]` holds the quotient and `accOut[15:8]` holds the remainder.
- R2: In word mode the dividend is `{dividendHi, dividendLo}` and the divisor is all 16 bits of `divisor`. On success `accOut` holds the quotient and `hiOut` holds the remainder.
- R3: In unsigned mode, if the quotient exceeds the destination width (byte mode above 255, word mode above 65535), the unit pulses `divErr`, does not pulse `done`, and leaves `accOut` and `hiOut` unchanged.
- R4: A zero divisor, in either mode and either signedness, pulses `divErr` and writes no result.
- R5: With `signedOp` high, the operands are two's-complement numbers. The quotient truncates toward zero, the remainder takes the sign of the dividend, and the results go to the same places as in R1 and R2.
- R6: In signed mode, a quotient outside -128..127 (byte mode) or outside -32768..32767 (word mode) pulses `divErr` and writes no result. A quotient of exactly -128 or -32768 is a valid result.
- R7: `busy` stays high for 11 cycles for a byte operation and for 19 cycles for a word operation. When the error is found before the loop (zero divisor, or upper dividend half magnitude >= divisor magnitude), `busy` stays high for 2 cycles.
- R8: `busy` rises on the cycle after an accepted start and falls on the cycle after the end pulse. A start pulse while `busy` is high is ignored.
- R9: Each operation ends with exactly one pulse, on either `done` or `divErr`, never both, and the pulse lasts one cycle. The pulse comes in the last cycle of `busy`, and the results are already visible on the outputs in that cycle.
- R10: A byte-mode operation never changes `hiOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a division |
| wordMode | input | 1 | 1: 32/16 division, 0: 16/8 division |
| signedOp | input | 1 | 1: two's-complement operands |
| dividendHi | input | 16 | Upper dividend word (word mode only) |
| dividendLo | input | 16 | Lower dividend word (the full dividend in byte mode) |
| divisor | input | 16 | Divisor (low byte used in byte mode) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results written |
| divErr | output | 1 | One-cycle pulse: divide error, nothing written |
| accOut | output | 16 | Accumulator result value |
| hiOut | output | 16 | Second data register result value |

## Verification
The divider is driven with small and large unsigned operands in both widths. These separate a correct shift-subtract loop from a loop with the wrong step count or wrong operand placement. Signed cases cover all four sign combinations, which separate truncation toward zero and remainder sign from floor division or a remainder that takes the sign of the divisor. At the edges, the bench uses a dividend whose upper half equals the divisor (pre-check overflow), zero divisors, the most negative dividend divided by -1 (post-loop overflow), and an exact most-negative quotient. These separate the two overflow paths and show that a failed operation leaves both result words untouched. A second start in the middle of an operation and a byte operation that follows a word operation check that busy masks requests and that the byte path never writes the upper result word.

// File: rtl/divPkg.sv
package divPkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CHK,
    S_ITER,
    S_FIX,
    S_WB
  } divState_t;

  typedef struct packed {
    logic load;
    logic step;
    logic commit;
  } divCtrl_t;
endpackage

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  divCtrl_t          ctrl,
  input  logic              wordMode,
  input  logic              signedOp,
  input  logic [DATA_W-1:0] dividendHi,
  input  logic [DATA_W-1:0] dividendLo,
  input  logic [DATA_W-1:0] divisor,
  output logic              wordQ,
  output logic              zeroDiv,
  output logic              earlyErr,
  output logic              lateErr,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] hiOut
);
  localparam int HALF = DATA_W / 2;
  localparam int WIDE = 2 * DATA_W;
  localparam logic [DATA_W-1:0] WORD_LIM = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] BYTE_LIM = DATA_W'(1) << (HALF - 1);

  logic [WIDE-1:0]   dvdExt, dvdMag;
  logic [DATA_W-1:0] dvsExt, dvsMag;
  logic              dvdNeg, dvsNeg;

  logic [DATA_W-1:0] remR, quoR, dvsR;
  logic              qNegR, rNegR, sgnR;

  logic [DATA_W:0]   trial;
  logic              trialGe;
  logic [DATA_W-1:0] qMag, qVal, rVal, qLim;

  // operand magnitudes and signs
  always_comb begin
    dvdExt = wordMode ? {dividendHi, dividendLo}
                      : {{DATA_W{signedOp & dividendLo[DATA_W-1]}}, dividendLo};
    dvdNeg = signedOp & dvdExt[WIDE-1];
    dvdMag = dvdNeg ? (~dvdExt + WIDE'(1)) : dvdExt;
    dvsExt = wordMode ? divisor
                      : {{HALF{signedOp & divisor[HALF-1]}}, divisor[HALF-1:0]};
    dvsNeg = signedOp & dvsExt[DATA_W-1];
    dvsMag = dvsNeg ? (~dvsExt + DATA_W'(1)) : dvsExt;
  end

  // one restoring step
  always_comb begin
    trial   = {remR, quoR[DATA_W-1]};
    trialGe = trial >= {1'b0, dvsR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      dvsR  <= '0;
      wordQ <= 1'b0;
      qNegR <= 1'b0;
      rNegR <= 1'b0;
      sgnR  <= 1'b0;
    end else if (ctrl.load) begin
      wordQ <= wordMode;
      sgnR  <= signedOp;
      qNegR <= dvdNeg ^ dvsNeg;
      rNegR <= dvdNeg;
      dvsR  <= dvsMag;
      if (wordMode) begin
        remR <= dvdMag[WIDE-1:DATA_W];
        quoR <= dvdMag[DATA_W-1:0];
      end else begin
        remR <= {{HALF{1'b0}}, dvdMag[DATA_W-1:HALF]};
        quoR <= {dvdMag[HALF-1:0], {HALF{1'b0}}};
      end
    end else if (ctrl.step) begin
      remR <= trialGe ? DATA_W'(trial - {1'b0, dvsR}) : trial[DATA_W-1:0];
      quoR <= {quoR[DATA_W-2:0], trialGe};
    end
  end

  // pre-loop check on the loaded magnitudes
  assign zeroDiv  = (dvsR == '0);
  assign earlyErr = zeroDiv || (remR >= dvsR);

  // post-loop sign restore and signed range check
  always_comb begin
    qMag    = wordQ ? quoR : {{HALF{1'b0}}, quoR[HALF-1:0]};
    qLim    = wordQ ? WORD_LIM : BYTE_LIM;
    lateErr = sgnR && (qNegR ? (qMag > qLim) : (qMag >= qLim));
    qVal    = qNegR ? (~qMag + DATA_W'(1)) : qMag;
    rVal    = rNegR ? (~remR + DATA_W'(1)) : remR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOut <= '0;
      hiOut  <= '0;
    end else if (ctrl.commit) begin
      if (wordQ) begin
        accOut <= qVal;
        hiOut  <= rVal;
      end else begin
        accOut <= {rVal[HALF-1:0], qVal[HALF-1:0]};
      end
    end
  end

  // a commit never occurs on a quotient that failed the range check
  p_commit_fits_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit |-> !lateErr);
  // loading and stepping are never requested together
  p_load_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.load && ctrl.step));
endmodule

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     wordQ,
  input  logic     zeroDiv,
  input  logic     earlyErr,
  input  logic     lateErr,
  output divCtrl_t ctrl,
  output logic     busy,
  output logic     done,
  output logic     divErr
);
  localparam int HALF  = DATA_W / 2;
  localparam int CNT_W = $clog2(DATA_W) + 1;

  divState_t       state;
  logic [CNT_W-1:0] cntR, lastCnt;
  logic            errR;

  assign lastCnt = wordQ ? CNT_W'(DATA_W - 1) : CNT_W'(HALF - 1);

  always_comb begin
    ctrl.load   = (state == S_IDLE) && start;
    ctrl.step   = (state == S_ITER);
    ctrl.commit = (state == S_FIX) && !lateErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cntR  <= '0;
      errR  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_CHK;
          errR  <= 1'b0;
        end
        S_CHK: begin
          cntR <= '0;
          if (earlyErr) begin
            errR  <= 1'b1;
            state <= S_WB;
          end else begin
            state <= S_ITER;
          end
        end
        S_ITER: begin
          cntR <= cntR + CNT_W'(1);
          if (cntR == lastCnt) state <= S_FIX;
        end
        S_FIX: begin
          errR  <= lateErr;
          state <= S_WB;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_WB) && !errR;
  assign divErr = (state == S_WB) && errR;

  p_single_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && divErr));
  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done || divErr) |=> !(done || divErr));
  p_zero_trap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHK && zeroDiv) |=> divErr);
  p_signed_ovf_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FIX && lateErr) |=> divErr);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && !divErr) |=> busy);
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done || divErr) |=> !busy);
endmodule

// File: rtl/intDivUnit.sv
module intDivUnit
  import divPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wordMode,
  input  logic              signedOp,
  input  logic [DATA_W-1:0] dividendHi,
  input  logic [DATA_W-1:0] dividendLo,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic              divErr,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] hiOut
);
  divCtrl_t ctrl;
  logic     wordQ, zeroDiv, earlyErr, lateErr;

  divControl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .wordQ(wordQ),
    .zeroDiv(zeroDiv), .earlyErr(earlyErr), .lateErr(lateErr),
    .ctrl(ctrl), .busy(busy), .done(done), .divErr(divErr)
  );

  divDatapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wordMode(wordMode),
    .signedOp(signedOp), .dividendHi(dividendHi), .dividendLo(dividendLo),
    .divisor(divisor), .wordQ(wordQ), .zeroDiv(zeroDiv),
    .earlyErr(earlyErr), .lateErr(lateErr), .accOut(accOut), .hiOut(hiOut)
  );

  p_err_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> ($stable(accOut) && $stable(hiOut)));
  p_byte_keeps_hi_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !wordQ) |-> $stable(hiOut));
endmodule

// File: tb/sim_intDivUnit.sv
module sim_intDivUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        wordMode = 1'b0;
  logic        signedOp = 1'b0;
  logic [15:0] dividendHi = '0;
  logic [15:0] dividendLo = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, divErr;
  logic [15:0] accOut, hiOut;

  int total = 0;
  int bad = 0;

  intDivUnit u0 (
    .clk(clk), .rstN(rstN), .start(start), .wordMode(wordMode),
    .signedOp(signedOp), .dividendHi(dividendHi), .dividendLo(dividendLo),
    .divisor(divisor), .busy(busy), .done(done), .divErr(divErr),
    .accOut(accOut), .hiOut(hiOut)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference values computed from the requirements
  task automatic expectOp(input bit w, input bit s, input logic [15:0] h,
                          input logic [15:0] l, input logic [15:0] d,
                          input logic [15:0] prevAcc, input logic [15:0] prevHi,
                          output bit err, output int cyc,
                          output logic [15:0] eAcc, output logic [15:0] eHi);
    longint a, dv, am, dm, q, r, upper;
    bit fit;
    if (w) begin
      a  = s ? longint'($signed({h, l})) : longint'({h, l});
      dv = s ? longint'($signed(d)) : longint'(d);
    end else begin
      a  = s ? longint'($signed(l)) : longint'(l);
      dv = s ? longint'($signed(d[7:0])) : longint'(d[7:0]);
    end
    am = (a < 0) ? -a : a;
    dm = (dv < 0) ? -dv : dv;
    upper = w ? (am >> 16) : (am >> 8);
    eAcc = prevAcc;
    eHi  = prevHi;
    if (dm == 0 || upper >= dm) begin
      err = 1'b1;
      cyc = 2;
      return;
    end
    cyc = w ? 19 : 11;
    q = a / dv;
    r = a % dv;
    if (s) fit = w ? (q >= -32768 && q <= 32767) : (q >= -128 && q <= 127);
    else   fit = w ? (q <= 65535) : (q <= 255);
    err = !fit;
    if (fit) begin
      if (w) begin
        eAcc = q[15:0];
        eHi  = r[15:0];
      end else begin
        eAcc = {r[7:0], q[7:0]};
      end
    end
  endtask

  // drives one operation; optionally pulses start again while busy
  task automatic runOp(input string req, input bit w, input bit s,
                       input logic [15:0] h, input logic [15:0] l,
                       input logic [15:0] d, input bit poke);
    bit eErr;
    int eCyc, busyCyc, doneCnt, errCnt, guard;
    logic [15:0] eAcc, eHi, accAtEnd, hiAtEnd;
    expectOp(w, s, h, l, d, accOut, hiOut, eErr, eCyc, eAcc, eHi);
    @(negedge clk);
    wordMode = w; signedOp = s; dividendHi = h; dividendLo = l; divisor = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyCyc = 0; doneCnt = 0; errCnt = 0; guard = 0;
    accAtEnd = accOut; hiAtEnd = hiOut;
    while (busy && guard < 100) begin
      busyCyc++;
      guard++;
      if (done || divErr) begin
        accAtEnd = accOut;
        hiAtEnd  = hiOut;
      end
      if (done) doneCnt++;
      if (divErr) errCnt++;
      if (poke && busyCyc == 1) begin
        dividendLo = 16'h0003; dividendHi = 16'h0000; divisor = 16'h0001;
        wordMode = ~w; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check("R7", {req, " busy cycles"}, busyCyc, eCyc);
    check("R9", {req, " end pulses"}, doneCnt + errCnt, 1);
    check(eErr ? "R3" : "R9", {req, " divErr"}, errCnt, eErr ? 1 : 0);
    check(req, {req, " accOut"}, accAtEnd, eAcc);
    check(req, {req, " hiOut"}, hiAtEnd, eHi);
    check("R8", {req, " idle after end"}, busy, 0);
  endtask

  task automatic tReset();
    check("R8", "reset busy", busy, 0);
    check("R9", "reset done", done, 0);
    check("R9", "reset divErr", divErr, 0);
    check("R1", "reset accOut", accOut, 0);
    check("R2", "reset hiOut", hiOut, 0);
  endtask

  task automatic tByteUnsigned();
    runOp("R1", 0, 0, 16'h0000, 16'd1000, 16'h0007, 0);   // 142 r 6
    runOp("R1", 0, 0, 16'hFFFF, 16'h00FF, 16'hAB00 | 16'h00FF, 0); // 255/255
    runOp("R1", 0, 0, 16'h0000, 16'hFEFF, 16'h00FF, 0);   // 255 r 254
  endtask

  task automatic tWordUnsigned();
    runOp("R2", 1, 0, 16'h0001, 16'h86A0, 16'd1000, 0);   // 100000/1000
    runOp("R2", 1, 0, 16'h0012, 16'h3456, 16'h1234, 0);
    runOp("R2", 1, 0, 16'hFFFE, 16'hFFFF, 16'hFFFF, 0);   // max quotient
  endtask

  task automatic tUnsignedOverflow();
    runOp("R3", 0, 0, 16'h0000, 16'h0500, 16'h0005, 0);
    runOp("R3", 1, 0, 16'h1234, 16'h0000, 16'h1234, 0);
  endtask

  task automatic tZeroDivisor();
    runOp("R4", 0, 0, 16'h0000, 16'h0010, 16'hFF00, 0);   // low byte zero
    runOp("R4", 1, 1, 16'h0000, 16'h0010, 16'h0000, 0);
  endtask

  task automatic tSigned();
    runOp("R5", 0, 1, 16'h0000, 16'hFF9C, 16'h0007, 0);   // -100/7
    runOp("R5", 0, 1, 16'h0000, 16'h0064, 16'h00F9, 0);   // 100/-7
    runOp("R5", 0, 1, 16'h0000, 16'hFF9C, 16'h00F9, 0);   // -100/-7
    runOp("R5", 1, 1, 16'hFFFF, 16'hFC18, 16'h0007, 0);   // -1000/7
    runOp("R5", 1, 1, 16'h0001, 16'h86A0, 16'hFFF9, 0);   // 100000/-7
    runOp("R6", 0, 1, 16'h0000, 16'hFF80, 16'h0001, 0);   // -128 fits
    runOp("R6", 1, 1, 16'hFFFF, 16'h8000, 16'h0001, 0);   // -32768 fits
  endtask

  task automatic tSignedOverflow();
    runOp("R6", 0, 1, 16'h0000, 16'hFF80, 16'h00FF, 0);   // -128/-1
    runOp("R6", 1, 1, 16'hFFFF, 16'h8000, 16'hFFFF, 0);   // -32768/-1
    runOp("R6", 0, 1, 16'h0000, 16'h0080, 16'h0001, 0);   // +128
  endtask

  task automatic tBusyIgnore();
    runOp("R8", 1, 0, 16'h0000, 16'd5000, 16'd7, 1);
  endtask

  task automatic tByteKeepsHi();
    runOp("R2", 1, 0, 16'h0000, 16'd1234, 16'd100, 0);    // hiOut = 34
    runOp("R10", 0, 0, 16'hBEEF, 16'd900, 16'h0011, 0);
    check("R10", "hiOut after byte op", hiOut, 16'd34);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tByteUnsigned();
    tWordUnsigned();
    tUnsignedOverflow();
    tZeroDivisor();
    tSigned();
    tSignedOverflow();
    tBusyIgnore();
    tByteKeepsHi();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule